// File: doc/BRIEF.md
# Program/Erase Sequencer with Status Register

This block runs the timed internal operations of a byte-wide nonvolatile memory. A command decoder sends it single-cycle requests: start a byte program, start a block erase, suspend, resume, and clear status. The sequencer steps through the phases of each operation. Each phase lasts for a cycle count given on an input, so that an integration can set the real durations. Pass or fail for an operation comes from a verify input that is sampled in the last cycle of the operation.

The block drives a ready/busy line and an 8-bit status word. The status word carries a ready flag, a suspended flag, and three sticky error flags: erase failed, program failed, and programming voltage low. There is also a second copy of the status word for a bus reader. This copy is captured when a read access begins and is held while the access lasts. An active-low power-down input aborts any operation and returns the status to its idle value. A programming-voltage-valid input is checked when an operation starts and in every cycle while it runs.

Top module: `pe_sequencer`

## Requirements
- R1: The status word is {ready, suspended, erase_err, write_err, vlow, 3'b000}. Bit 7 is 1 when no operation runs. Bit 6 is 1 while an erase is suspended. Bits 5, 4 and 3 are the error flags. Bits 2..0 always read 0. When idle with no errors, the status reads 8'h80.
- R2: While `pd_n` is low, `ready` is 1 in the same cycle. From the first clock edge with `pd_n` low, any operation is abandoned, the status reads 8'h80 and all requests are ignored.
- R3: A program request accepted in idle makes `ready` low from the next cycle for exactly `t_write` cycles (a length of 0 counts as 1). `ready` then returns high.
- R4: An erase request accepted in idle runs three phases back to back: precondition, erase and verify. It keeps `ready` low for `t_precond + t_erase + t_verify` cycles.
- R5: If `verify_ok` is 0 in the last cycle of a program, bit 4 is set. If it is 0 in the last cycle of an erase, bit 5 is set.
- R6: Bits 5, 4 and 3 stay set across later operations. Only a clear request, or power-down, resets them.
- R7: A program or erase request while `hv_ok` is 0 sets bit 3 and does not start: `ready` stays high.
- R8: While bit 3 is set, program and erase requests are refused until a clear request arrives.
- R9: If `hv_ok` falls while an operation runs, the operation aborts on that edge. Bit 3 is set and `ready` goes high.
- R10: A suspend request during the precondition or erase phase takes effect at the end of the current phase. The status then reads bits 7 and 6 both set, and `ready` is high. A suspend request during the verify phase is ignored.
- R11: A resume request while suspended clears bits 7 and 6 and drops `ready`. The next phase then runs for its full length.
- R12: Program and erase requests that arrive while an operation runs or is suspended are ignored.
- R13: `status_snap` takes the status value of the first cycle in which `rd_ce_n` and `rd_oe_n` are both low. It keeps that value until one of them goes high and both go low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Active-low power-down; aborts any operation |
| hv_ok | input | 1 | Programming voltage is valid |
| req_write | input | 1 | Start byte program (one-cycle pulse) |
| req_erase | input | 1 | Start block erase (one-cycle pulse) |
| req_suspend | input | 1 | Request erase suspend |
| req_resume | input | 1 | Resume a suspended erase |
| req_clear | input | 1 | Clear the sticky error flags |
| verify_ok | input | 1 | Verify result, sampled in the last cycle of an operation |
| t_write | input | CNT_W | Program duration in cycles |
| t_precond | input | CNT_W | Precondition phase duration |
| t_erase | input | CNT_W | Erase phase duration |
| t_verify | input | CNT_W | Erase verify phase duration |
| rd_ce_n | input | 1 | Reader chip enable, active low |
| rd_oe_n | input | 1 | Reader output enable, active low |
| ready | output | 1 | High when idle, suspended or powered down |
| status | output | 8 | Live status word |
| status_snap | output | 8 | Status captured at the start of a read access |

## Verification
Every status and snapshot change is registered, so it appears one clock edge after the request or phase end that causes it. The exception is `ready`, which reacts to `pd_n` without waiting for an edge. A program sampled at edge A shows busy from A+1 through A+`t_write`. A suspend becomes visible one edge after the phase boundary where it is honoured. The bench drives inputs just after the falling clock edge and samples outputs on the falling edge, one half period after the registers update. It compares them against a behavioural model that advances on every rising edge. Directed checks count the busy cycles with the same falling-edge sampling.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WRITE    = 3'd1,
        ST_PRECOND  = 3'd2,
        ST_ERASE    = 3'd3,
        ST_VERIFY   = 3'd4,
        ST_SUSPEND  = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        seq_state_e resume_st;
        logic       susp_pend;
    } seq_regs_t;

    // indices into the sticky flag vector
    localparam int FLAG_VLOW = 0;
    localparam int FLAG_WERR = 1;
    localparam int FLAG_EERR = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/pe_phase_timer.sv
module pe_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = (len == '0) ? '0 : len - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pe_err_flags.sv
module pe_err_flags #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             clr,
    input  logic [NFLAG-1:0] set,
    output logic [NFLAG-1:0] flags
);
    logic [NFLAG-1:0] flag_d, flag_q;

    always_comb begin
        for (int i = 0; i < NFLAG; i++) begin
            if (wipe) flag_d[i] = 1'b0;
            else      flag_d[i] = (flag_q[i] & ~clr) | set[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags = flag_q;
endmodule

// File: rtl/pe_status_snap.sv
module pe_status_snap #(
    parameter int          W         = 8,
    parameter logic [W-1:0] RST_VALUE = 8'h80
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce_n,
    input  logic         oe_n,
    input  logic [W-1:0] live,
    output logic [W-1:0] snap
);
    typedef struct packed {
        logic         sel;
        logic [W-1:0] val;
    } snap_regs_t;

    snap_regs_t s_d, s_q;
    logic       sel_now;

    assign sel_now = !ce_n && !oe_n;

    always_comb begin
        s_d     = s_q;
        s_d.sel = sel_now;
        if (sel_now && !s_q.sel) s_d.val = live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{sel: 1'b0, val: RST_VALUE};
        else        s_q <= s_d;
    end

    assign snap = s_q.val;
endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
    import pe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             hv_ok,
    input  logic             req_write,
    input  logic             req_erase,
    input  logic             req_suspend,
    input  logic             req_resume,
    input  logic             req_clear,
    input  logic             verify_ok,
    input  logic [CNT_W-1:0] t_write,
    input  logic [CNT_W-1:0] t_precond,
    input  logic [CNT_W-1:0] t_erase,
    input  logic [CNT_W-1:0] t_verify,
    input  logic             rd_ce_n,
    input  logic             rd_oe_n,
    output logic             ready,
    output logic [7:0]       status,
    output logic [7:0]       status_snap
);
    seq_regs_t            r_d, r_q;
    seq_state_e           ld_st;
    seq_state_e           follow_st;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_len;
    logic                 tmr_done;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flags;
    logic                 idle_like;
    logic [7:0]           status_live;

    // next-state logic
    always_comb begin
        r_d       = r_q;
        ld_st     = ST_IDLE;
        flag_set  = '0;
        follow_st = (r_q.st == ST_PRECOND) ? ST_ERASE : ST_VERIFY;
        if (!pd_n) begin
            r_d.st        = ST_IDLE;
            r_d.resume_st = ST_IDLE;
            r_d.susp_pend = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (!flags[FLAG_VLOW]) begin
                        if (req_write) begin
                            if (hv_ok) begin
                                r_d.st = ST_WRITE;
                                ld_st  = ST_WRITE;
                            end else begin
                                flag_set[FLAG_VLOW] = 1'b1;
                            end
                        end else if (req_erase) begin
                            if (hv_ok) begin
                                r_d.st = ST_PRECOND;
                                ld_st  = ST_PRECOND;
                            end else begin
                                flag_set[FLAG_VLOW] = 1'b1;
                            end
                        end
                    end
                end
                ST_WRITE: begin
                    if (!hv_ok) begin
                        r_d.st              = ST_IDLE;
                        flag_set[FLAG_VLOW] = 1'b1;
                    end else if (tmr_done) begin
                        r_d.st              = ST_IDLE;
                        flag_set[FLAG_WERR] = !verify_ok;
                    end
                end
                ST_PRECOND, ST_ERASE: begin
                    r_d.susp_pend = r_q.susp_pend | req_suspend;
                    if (!hv_ok) begin
                        r_d.st              = ST_IDLE;
                        r_d.susp_pend       = 1'b0;
                        flag_set[FLAG_VLOW] = 1'b1;
                    end else if (tmr_done) begin
                        if (r_q.susp_pend || req_suspend) begin
                            r_d.st        = ST_SUSPEND;
                            r_d.resume_st = follow_st;
                            r_d.susp_pend = 1'b0;
                        end else begin
                            r_d.st = follow_st;
                            ld_st  = follow_st;
                        end
                    end
                end
                ST_VERIFY: begin
                    r_d.susp_pend = 1'b0;
                    if (!hv_ok) begin
                        r_d.st              = ST_IDLE;
                        flag_set[FLAG_VLOW] = 1'b1;
                    end else if (tmr_done) begin
                        r_d.st              = ST_IDLE;
                        flag_set[FLAG_EERR] = !verify_ok;
                    end
                end
                ST_SUSPEND: begin
                    if (req_resume) begin
                        r_d.st = r_q.resume_st;
                        ld_st  = r_q.resume_st;
                    end
                end
                default: begin
                    r_d.st = ST_IDLE;
                end
            endcase
        end
    end

    // phase length selection for the timer load
    always_comb begin
        tmr_load = (ld_st != ST_IDLE);
        unique case (ld_st)
            ST_WRITE:   tmr_len = t_write;
            ST_PRECOND: tmr_len = t_precond;
            ST_ERASE:   tmr_len = t_erase;
            ST_VERIFY:  tmr_len = t_verify;
            default:    tmr_len = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, resume_st: ST_IDLE, susp_pend: 1'b0};
        else        r_q <= r_d;
    end

    pe_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    pe_err_flags #(.NFLAG(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (!pd_n),
        .clr   (req_clear),
        .set   (flag_set),
        .flags (flags)
    );

    assign idle_like   = (r_q.st == ST_IDLE) || (r_q.st == ST_SUSPEND);
    assign status_live = {idle_like, (r_q.st == ST_SUSPEND), flags[FLAG_EERR],
                          flags[FLAG_WERR], flags[FLAG_VLOW], 3'b000};

    pe_status_snap #(.W(8), .RST_VALUE(8'h80)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (rd_ce_n),
        .oe_n  (rd_oe_n),
        .live  (status_live),
        .snap  (status_snap)
    );

    assign status = status_live;
    assign ready  = !pd_n || idle_like;
endmodule

// File: rtl/pe_sequencer_chk.sv
module pe_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pd_n,
    input logic       hv_ok,
    input logic       req_clear,
    input logic       ready,
    input logic [7:0] status
);
    // R2: power-down returns the status to its idle value on the next edge
    a_r2_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (status == 8'h80));

    // R2: ready is high during power-down
    a_r2_pd_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |-> ready);

    // R10: a suspended erase reads ready in both the status and the pin
    a_r10_susp_ready: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> (status[7] && ready));

    // R6: the erase error flag survives until cleared
    a_r6_eerr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && status[5] && !req_clear) |=> status[5]);

    // R8: with the voltage-low flag set, an idle sequencer stays idle
    a_r8_vlow_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && status[3] && status[7] && !status[6]) |=> status[7]);

    // R9: a voltage drop during a running operation aborts it
    a_r9_hv_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !ready && !hv_ok) |=> (ready && status[3]));
endmodule

bind pe_sequencer pe_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .hv_ok     (hv_ok),
    .req_clear (req_clear),
    .ready     (ready),
    .status    (status)
);

// File: tb/sim_pe_sequencer.sv
module sim_pe_sequencer;
    localparam int CNT_W  = 16;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0, pd_n = 1'b1, hv_ok = 1'b1;
    logic req_write = 1'b0, req_erase = 1'b0, req_suspend = 1'b0;
    logic req_resume = 1'b0, req_clear = 1'b0, verify_ok = 1'b1;
    logic [CNT_W-1:0] t_write = 4, t_precond = 3, t_erase = 6, t_verify = 2;
    logic rd_ce_n = 1'b1, rd_oe_n = 1'b1;
    logic ready;
    logic [7:0] status, status_snap;

    always #(PERIOD/2) clk = ~clk;

    pe_sequencer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .hv_ok(hv_ok),
        .req_write(req_write), .req_erase(req_erase), .req_suspend(req_suspend),
        .req_resume(req_resume), .req_clear(req_clear), .verify_ok(verify_ok),
        .t_write(t_write), .t_precond(t_precond), .t_erase(t_erase), .t_verify(t_verify),
        .rd_ce_n(rd_ce_n), .rd_oe_n(rd_oe_n),
        .ready(ready), .status(status), .status_snap(status_snap)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    string cur_tag  = "R2";

    // behavioural reference model
    localparam int M_IDLE = 0, M_WR = 1, M_PRE = 2, M_ER = 3, M_VF = 4, M_SP = 5;
    int       mst = M_IDLE, mleft = 0, mnext = M_IDLE, nxt = 0;
    bit       mpend = 0, e3 = 0, e4 = 0, e5 = 0, msel = 0;
    bit       s3, s4, s5;
    logic [7:0] msnap = 8'h80;

    function automatic int ld(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int plen(input int p);
        case (p)
            M_WR:    return int'(t_write);
            M_PRE:   return int'(t_precond);
            M_ER:    return int'(t_erase);
            default: return int'(t_verify);
        endcase
    endfunction

    function automatic logic [7:0] mstatus();
        return {(mst == M_IDLE || mst == M_SP), (mst == M_SP), e5, e4, e3, 3'b000};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mst = M_IDLE; mleft = 0; mnext = M_IDLE; mpend = 0;
            e3 = 0; e4 = 0; e5 = 0; msnap = 8'h80; msel = 0;
        end else begin
            if (!rd_ce_n && !rd_oe_n && !msel) msnap = mstatus();
            msel = !rd_ce_n && !rd_oe_n;
            if (!pd_n) begin
                mst = M_IDLE; mpend = 0; e3 = 0; e4 = 0; e5 = 0;
            end else begin
                s3 = 0; s4 = 0; s5 = 0;
                case (mst)
                    M_IDLE: if (!e3) begin
                        if (req_write) begin
                            if (hv_ok) begin mst = M_WR; mleft = ld(plen(M_WR)); end
                            else s3 = 1;
                        end else if (req_erase) begin
                            if (hv_ok) begin mst = M_PRE; mleft = ld(plen(M_PRE)); end
                            else s3 = 1;
                        end
                    end
                    M_WR: begin
                        if (!hv_ok) begin mst = M_IDLE; s3 = 1; end
                        else if (mleft == 1) begin mst = M_IDLE; s4 = !verify_ok; end
                        else mleft--;
                    end
                    M_PRE, M_ER: begin
                        if (req_suspend) mpend = 1;
                        if (!hv_ok) begin mst = M_IDLE; s3 = 1; mpend = 0; end
                        else if (mleft == 1) begin
                            nxt = (mst == M_PRE) ? M_ER : M_VF;
                            if (mpend) begin mst = M_SP; mnext = nxt; mpend = 0; end
                            else begin mst = nxt; mleft = ld(plen(nxt)); end
                        end else mleft--;
                    end
                    M_VF: begin
                        if (!hv_ok) begin mst = M_IDLE; s3 = 1; end
                        else if (mleft == 1) begin mst = M_IDLE; s5 = !verify_ok; end
                        else mleft--;
                    end
                    default: if (req_resume) begin mst = mnext; mleft = ld(plen(mnext)); end
                endcase
                e3 = (e3 && !req_clear) || s3;
                e4 = (e4 && !req_clear) || s4;
                e5 = (e5 && !req_clear) || s5;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // per-cycle comparison against the model, plus watchdog
    always @(negedge clk) begin
        cycles++;
        check({cur_tag, " ready"}, int'(ready), int'(!pd_n || mst == M_IDLE || mst == M_SP));
        check({cur_tag, " status R1"}, int'(status), int'(mstatus()));
        check({cur_tag, " snapshot R13"}, int'(status_snap), int'(msnap));
        if (cycles > 20000) begin
            check("watchdog", 0, 1);
            finish_run();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // 0 write, 1 erase, 2 suspend, 3 resume, 4 clear
    task automatic do_req(input int which);
        @(negedge clk); #1;
        case (which)
            0: req_write = 1'b1;
            1: req_erase = 1'b1;
            2: req_suspend = 1'b1;
            3: req_resume = 1'b1;
            default: req_clear = 1'b1;
        endcase
        @(negedge clk); #1;
        req_write = 1'b0; req_erase = 1'b0; req_suspend = 1'b0;
        req_resume = 1'b0; req_clear = 1'b0;
    endtask

    task automatic measure_busy(input string tag, input int exp);
        int cnt = 0;
        while (!ready && cnt < 1000) begin
            cnt++;
            @(negedge clk); #1;
        end
        check({tag, " busy cycles"}, cnt, exp);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R2 reset status", int'(status), 8'h80);
        check("R2 reset ready", int'(ready), 1);

        cur_tag = "R3";
        do_req(0); measure_busy("R3", 4);
        check("R1 idle encoding", int'(status), 8'h80);

        cur_tag = "R5";
        verify_ok = 1'b0; do_req(0); measure_busy("R3", 4); verify_ok = 1'b1;
        check("R5 write error", int'(status), 8'h90);

        cur_tag = "R6";
        do_req(0); measure_busy("R3", 4);
        check("R6 flag kept", int'(status), 8'h90);
        verify_ok = 1'b0; do_req(1); measure_busy("R4", 11); verify_ok = 1'b1;
        check("R5 erase error accumulates", int'(status), 8'hB0);
        do_req(4);
        check("R6 cleared", int'(status), 8'h80);

        cur_tag = "R4";
        do_req(1); measure_busy("R4", 11);
        check("R4 erase ok", int'(status), 8'h80);

        cur_tag = "R7";
        hv_ok = 1'b0; do_req(0);
        check("R7 vlow set", int'(status), 8'h88);
        check("R7 not started", int'(ready), 1);
        hv_ok = 1'b1;
        cur_tag = "R8";
        do_req(1);
        check("R8 start refused", int'(ready), 1);
        check("R8 status kept", int'(status), 8'h88);
        do_req(4); do_req(1); measure_busy("R8", 11);

        cur_tag = "R9";
        do_req(1); wait_cyc(4);
        hv_ok = 1'b0; wait_cyc(1); hv_ok = 1'b1;
        check("R9 aborted ready", int'(ready), 1);
        check("R9 aborted status", int'(status), 8'h88);
        do_req(4);

        cur_tag = "R10";
        do_req(1); do_req(2); wait_cyc(4);
        check("R10 suspended status", int'(status), 8'hC0);
        check("R10 suspended ready", int'(ready), 1);
        cur_tag = "R12";
        do_req(0);
        check("R12 write ignored while suspended", int'(status), 8'hC0);
        cur_tag = "R11";
        do_req(3); measure_busy("R11", 8);
        check("R11 resumed and done", int'(status), 8'h80);

        cur_tag = "R10";
        do_req(1); wait_cyc(8); do_req(2); wait_cyc(3);
        check("R10 suspend in verify ignored", int'(status), 8'h80);

        cur_tag = "R12";
        do_req(0); do_req(1); wait_cyc(3);
        check("R12 erase ignored while busy ready", int'(ready), 1);
        check("R12 erase ignored while busy status", int'(status), 8'h80);

        cur_tag = "R13";
        do_req(1);
        rd_ce_n = 1'b0; rd_oe_n = 1'b0;
        wait_cyc(14);
        check("R13 snapshot held", int'(status_snap), 8'h00);
        check("R13 live moved on", int'(status), 8'h80);
        rd_oe_n = 1'b1; wait_cyc(1); rd_oe_n = 1'b0; wait_cyc(2);
        check("R13 snapshot refreshed", int'(status_snap), 8'h80);
        rd_ce_n = 1'b1; rd_oe_n = 1'b1;

        cur_tag = "R3";
        t_write = 0; do_req(0); measure_busy("R3 zero length", 1); t_write = 4;

        cur_tag = "R2";
        verify_ok = 1'b0; do_req(0); measure_busy("R3", 4); verify_ok = 1'b1;
        do_req(1); wait_cyc(3);
        pd_n = 1'b0; #1;
        check("R2 ready during power-down", int'(ready), 1);
        wait_cyc(1);
        check("R2 status after power-down", int'(status), 8'h80);
        do_req(0);
        check("R2 request ignored in power-down", int'(status), 8'h80);
        pd_n = 1'b1; wait_cyc(2);
        do_req(0); measure_busy("R2 after wake", 4);

        wait_cyc(2);
        finish_run();
    end
endmodule